// File: doc/BRIEF.md
# Predicated Loop Counter Unit

This unit is a functional-unit loop counter for a dataflow tile array. It is loaded with a lower bound, a stride and an exclusive upper bound. On a start strobe it emits the index sequence lower, lower+stride, and so on, over a valid/ready stream. Each index carries a predicate bit that marks the final index of the pass, so downstream logic can gate the loop's final result. Only this innermost level increments itself; outer loop levels are handled elsewhere.

When a pass is exhausted, the unit raises one command on a separate valid/ready command channel. The command depends on the operating mode loaded with the configuration. In standalone mode the counter is the whole loop, so it reports completion to the array controller and then stays idle until it is reconfigured. In chained mode the counter is the innermost level of a nest. It asks the outer nest controller to update the outer loop values, then waits for a retrigger strobe that reloads the lower bound and runs the pass again.

Top module: `loop_idx_counter`

## Requirements
- R1: After reset, neither idx_valid nor cmd_valid is high.
- R2: After a start, the indices accepted on the stream are exactly lower, lower+step, lower+2*step and so on, while the value is strictly below the upper bound. All values are unsigned.
- R3: While idx_valid is high and idx_ready is low, idx_valid stays high and idx_data and idx_pred hold their values. The index advances only on a cycle with both valid and ready high.
- R4: idx_pred is 1 on the final index of a pass and 0 on every other index.
- R5: In standalone mode (cfg_op = 0), exhaustion presents cmd_code 2'b01 (completion). The command is held until cmd_ready.
- R6: In chained mode (cfg_op = 1), exhaustion presents cmd_code 2'b10 (outer-update request). The command is held until cmd_ready.
- R7: If the lower bound is at or above the upper bound, a start emits no index. The terminal command appears on the first cycle after the start.
- R8: The terminal command is given for exactly one handshake per pass. It does not reappear while the unit waits afterwards, and it is never valid at the same time as an index.
- R9: In chained mode, a kick after the command handshake reloads the lower bound and repeats the pass. A kick during counting, or while the command is pending, has no effect.
- R10: In standalone mode, after the completion handshake a kick has no effect. Only a cfg_load re-arms the unit, after which a kick starts a new pass.
- R11: A next index that would exceed the range of the index width ends the pass. It never wraps to a small value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load the configuration and return to idle |
| cfg_op | input | 1 | Mode: 0 standalone, 1 chained |
| cfg_lo | input | W | Lower bound (first index) |
| cfg_step | input | W | Stride |
| cfg_hi | input | W | Exclusive upper bound |
| kick | input | 1 | Start / retrigger strobe |
| idx_valid | output | 1 | Index stream valid |
| idx_ready | input | 1 | Index stream ready |
| idx_data | output | W | Current index |
| idx_pred | output | 1 | Final-index predicate |
| cmd_valid | output | 1 | Terminal command valid |
| cmd_ready | input | 1 | Terminal command accepted |
| cmd_code | output | 2 | Command code: 01 completion, 10 outer update |

## Verification
The bench builds the unit with an 8-bit index width instead of the 16-bit default. This makes the top of the index range reachable with small numbers: a lower bound of 252, a stride of 2 and an upper bound of 255 forces the carry-out case of R11, where a wrapping counter would restart at zero and keep counting. The narrow width also keeps every pass short. Because of that, a 32-index pass, stalled passes, single-index passes and empty passes in both modes all fit in one table walk, along with the retrigger and re-arm sequences.

// File: rtl/lic_pkg.sv
package lic_pkg;

  typedef enum logic [0:0] {
    OP_SOLO  = 1'b0,
    OP_CHAIN = 1'b1
  } lic_op_e;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'b00,
    CMD_COMPLETE = 2'b01,
    CMD_UPDATE   = 2'b10
  } lic_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_TERM = 3'd2,
    ST_WAIT = 3'd3,
    ST_DONE = 3'd4
  } lic_state_e;

endpackage

// File: rtl/lic_cfg_regs.sv
module lic_cfg_regs #(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 op_in,
  input  logic [W-1:0]         lo_in,
  input  logic [W-1:0]         step_in,
  input  logic [W-1:0]         hi_in,
  output lic_pkg::lic_op_e     op,
  output logic [W-1:0]         lo,
  output logic [W-1:0]         step,
  output logic [W-1:0]         hi
);
  import lic_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op   <= OP_SOLO;
      lo   <= '0;
      step <= '0;
      hi   <= '0;
    end else if (load) begin
      op   <= lic_op_e'(op_in);
      lo   <= lo_in;
      step <= step_in;
      hi   <= hi_in;
    end
  end

endmodule

// File: rtl/lic_stepper.sv
module lic_stepper #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] step,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] nxt,
  output logic         nxt_ok,
  output logic         lo_ok
);
  localparam int WX = W + 1;

  // Add with one carry bit so that an overflow is visible.
  function automatic logic [WX-1:0] f_add_wide(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // A value is usable only when it has no carry-out and is below the bound.
  function automatic logic f_fits(input logic [WX-1:0] v, input logic [W-1:0] bound);
    return (v[WX-1] == 1'b0) && (v[W-1:0] < bound);
  endfunction

  logic [WX-1:0] sum_wide;

  always_comb begin
    sum_wide = f_add_wide(cur, step);
    nxt      = sum_wide[W-1:0];
    nxt_ok   = f_fits(sum_wide, hi);
    lo_ok    = f_fits({1'b0, lo}, hi);
  end

endmodule

// File: rtl/lic_seq.sv
module lic_seq #(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  lic_pkg::lic_op_e     op,
  input  logic [W-1:0]         lo,
  input  logic [W-1:0]         step,
  input  logic [W-1:0]         hi,
  input  logic [W-1:0]         nxt,
  input  logic                 nxt_ok,
  input  logic                 lo_ok,
  input  logic                 kick,
  input  logic                 idx_ready,
  input  logic                 cmd_ready,
  output logic [W-1:0]         cur,
  output logic                 idx_valid,
  output logic                 idx_pred,
  output logic                 cmd_valid,
  output logic [1:0]           cmd_code
);
  import lic_pkg::*;

  lic_state_e state;

  // Named internal events
  logic ev_fire;   // index handshake
  logic ev_term;   // command handshake
  logic ev_arm;    // a kick that starts a pass
  logic in_done;

  assign ev_fire = idx_valid && idx_ready;
  assign ev_term = cmd_valid && cmd_ready;
  assign ev_arm  = kick && ((state == ST_IDLE) || (state == ST_WAIT));
  assign in_done = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= '0;
    end else if (cfg_load) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE, ST_WAIT: begin
          if (kick) begin
            cur   <= lo;
            state <= lo_ok ? ST_RUN : ST_TERM;
          end
        end
        ST_RUN: begin
          if (idx_ready) begin
            if (nxt_ok) cur <= nxt;
            else        state <= ST_TERM;
          end
        end
        ST_TERM: begin
          if (cmd_ready) state <= (op == OP_CHAIN) ? ST_WAIT : ST_DONE;
        end
        default: state <= state;
      endcase
    end
  end

  always_comb begin
    idx_valid = (state == ST_RUN);
    idx_pred  = (state == ST_RUN) && !nxt_ok;
    cmd_valid = (state == ST_TERM);
    if (state != ST_TERM)    cmd_code = CMD_NONE;
    else if (op == OP_CHAIN) cmd_code = CMD_UPDATE;
    else                     cmd_code = CMD_COMPLETE;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !idx_valid && !cmd_valid);

  a_r2_below_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> cur < hi);

  a_r3_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && !idx_ready && !cfg_load |=> idx_valid && $stable(cur) && $stable(idx_pred));

  a_r4_pred_then_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire && idx_pred && !cfg_load |=> cmd_valid);

  a_r5_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !cfg_load |=> cmd_valid && $stable(cmd_code));

  a_r7_empty_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arm && !cfg_load && !(lo < hi) |=> cmd_valid && !idx_valid);

  a_r8_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ev_term |=> !cmd_valid);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_valid && cmd_valid));

  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arm && !cfg_load && (lo < hi) |=> idx_valid && cur == $past(lo));

  a_r10_done_ignores_kick: assert property (@(posedge clk) disable iff (!rst_n)
    in_done && !cfg_load |=> in_done && !idx_valid && !cmd_valid);

  a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire && !idx_pred && !cfg_load && (step != '0) |=> idx_valid && cur > $past(cur));

endmodule

// File: rtl/loop_idx_counter.sv
module loop_idx_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_load,
  input  logic         cfg_op,
  input  logic [W-1:0] cfg_lo,
  input  logic [W-1:0] cfg_step,
  input  logic [W-1:0] cfg_hi,
  input  logic         kick,
  output logic         idx_valid,
  input  logic         idx_ready,
  output logic [W-1:0] idx_data,
  output logic         idx_pred,
  output logic         cmd_valid,
  input  logic         cmd_ready,
  output logic [1:0]   cmd_code
);
  import lic_pkg::*;

  lic_op_e      op;
  logic [W-1:0] lo, step, hi, cur, nxt;
  logic         nxt_ok, lo_ok;

  lic_cfg_regs #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .op_in(cfg_op),
    .lo_in(cfg_lo), .step_in(cfg_step), .hi_in(cfg_hi),
    .op(op), .lo(lo), .step(step), .hi(hi)
  );

  lic_stepper #(.W(W)) u_step (
    .cur(cur), .step(step), .lo(lo), .hi(hi),
    .nxt(nxt), .nxt_ok(nxt_ok), .lo_ok(lo_ok)
  );

  lic_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .op(op),
    .lo(lo), .step(step), .hi(hi), .nxt(nxt), .nxt_ok(nxt_ok), .lo_ok(lo_ok),
    .kick(kick), .idx_ready(idx_ready), .cmd_ready(cmd_ready),
    .cur(cur), .idx_valid(idx_valid), .idx_pred(idx_pred),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  assign idx_data = cur;

endmodule

// File: tb/loop_idx_counter_tb_top.sv
module loop_idx_counter_tb_top;
  localparam int W = 8;

  typedef struct packed {
    logic       op;
    logic [7:0] lo;
    logic [7:0] step;
    logic [7:0] hi;
    logic       stall;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{op: 1'b0, lo: 8'd0,   step: 8'd1, hi: 8'd32,  stall: 1'b0},
    '{op: 1'b1, lo: 8'd3,   step: 8'd4, hi: 8'd20,  stall: 1'b1},
    '{op: 1'b0, lo: 8'd10,  step: 8'd5, hi: 8'd10,  stall: 1'b0},
    '{op: 1'b1, lo: 8'd252, step: 8'd2, hi: 8'd255, stall: 1'b1},
    '{op: 1'b0, lo: 8'd5,   step: 8'd7, hi: 8'd6,   stall: 1'b1},
    '{op: 1'b1, lo: 8'd20,  step: 8'd1, hi: 8'd4,   stall: 1'b0}
  };

  logic clk = 0, rst_n = 0, cfg_load = 0, cfg_op = 0, kick = 0;
  logic [W-1:0] cfg_lo = 0, cfg_step = 0, cfg_hi = 0, idx_data;
  logic idx_valid, idx_ready = 0, idx_pred, cmd_valid, cmd_ready = 0;
  logic [1:0] cmd_code;
  int checks = 0, misses = 0;

  always #5 clk = ~clk;

  loop_idx_counter #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_op(cfg_op),
    .cfg_lo(cfg_lo), .cfg_step(cfg_step), .cfg_hi(cfg_hi), .kick(kick),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
    .idx_pred(idx_pred), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input vec_t v);
    @(negedge clk);
    cfg_op = v.op; cfg_lo = v.lo; cfg_step = v.step; cfg_hi = v.hi; cfg_load = 1;
    @(posedge clk); #1 cfg_load = 0;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1;
    @(posedge clk); #1 kick = 0;
  endtask

  // Walks one pass and compares every accepted index with the expected sequence.
  task automatic run_pass(input vec_t v);
    int e = v.lo;
    int n_exp = 0;
    int n_got = 0;
    bit stalled = 0;
    int held = 0;
    for (int x = v.lo; x < v.hi; x += v.step) n_exp++;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      idx_ready = v.stall ? (c % 3 != 1) : 1'b1;
      kick = v.stall && (c % 4 == 2);
      #1;
      if (stalled) check(idx_valid && idx_data == held, "R3 hold while stalled", idx_data, held);
      stalled = 0;
      if (cmd_valid) break;
      if (idx_valid) begin
        if (idx_ready) begin
          check(idx_data == e, "R2 index value", idx_data, e);
          check(idx_pred == (e + v.step >= v.hi), "R4 predicate", idx_pred, (e + v.step >= v.hi));
          e += v.step;
          n_got++;
        end else begin
          stalled = 1;
          held = idx_data;
        end
      end
    end
    kick = 0;
    idx_ready = 0;
    check(n_got == n_exp, (n_exp == 0) ? "R7 no index on empty range" : "R11 R2 index count",
          n_got, n_exp);
  endtask

  task automatic take_cmd(input logic op);
    int exp = op ? 2 : 1;
    check(cmd_valid && cmd_code == exp[1:0], op ? "R6 update code" : "R5 completion code",
          cmd_code, exp);
    check(!idx_valid, "R8 no index beside command", idx_valid, 0);
    @(negedge clk); #1;
    check(cmd_valid && cmd_code == exp[1:0], "R5 R6 command held", cmd_code, exp);
    cmd_ready = 1;
    @(posedge clk); #1 cmd_ready = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(!cmd_valid && !idx_valid, "R8 single command per pass", cmd_valid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check(!idx_valid && !cmd_valid, "R1 reset quiet", {idx_valid, cmd_valid}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check(!idx_valid && !cmd_valid, "R1 idle after reset", {idx_valid, cmd_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      load_cfg(VECS[i]);
      pulse_kick();
      run_pass(VECS[i]);
      take_cmd(VECS[i].op);
      if (VECS[i].op) begin
        // R9 retrigger repeats the pass from the lower bound
        pulse_kick();
        run_pass(VECS[i]);
        take_cmd(VECS[i].op);
      end else begin
        pulse_kick();
        for (int k = 0; k < 3; k++) begin
          @(negedge clk); #1;
          check(!idx_valid && !cmd_valid, "R10 kick ignored after completion",
                {idx_valid, cmd_valid}, 0);
        end
      end
    end

    // R10 re-arm through cfg_load after standalone completion
    load_cfg(VECS[4]);
    pulse_kick();
    run_pass(VECS[4]);
    take_cmd(1'b0);
    load_cfg(VECS[4]);
    pulse_kick();
    @(negedge clk); #1;
    check(idx_valid && idx_data == 5, "R10 re-armed pass starts at lower bound", idx_data, 5);
    run_pass(VECS[4]);
    take_cmd(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

endmodule